// File: doc/BRIEF.md
# Ultra DMA Burst Engine

This block is the host side of an Ultra DMA burst on a 16-bit ATA channel. Software-side logic requests a burst by giving a direction and a word count. The engine waits until the device raises its DMA request and no PIO cycle is running. It then asserts the DMA acknowledge, and the PIO read and write strobe pins take on their Ultra DMA meanings. On a write to the disk, the host strobe pin toggles once for each word, and each edge, rising or falling, carries one data word. On a read from the disk, every edge of the device's strobe delivers one word. The host paces the device through its own active-low ready on the same strobe pin.

The device strobe and the device ready both arrive on one input pin. That pin is brought into the system clock through a two-flop synchronizer, and edges are detected there. No logic is clocked from the pin. Toward the system, the block pops transmit words from a FIFO-style source and pushes received words into a sink that reports when it is nearly full. A burst ends when the count is used up or when transmit data runs out. The host then raises the stop pin for one cycle. In the next cycle it releases the acknowledge and drives a CRC-16 of every transferred word on the data bus. After that cycle the pins return to PIO meaning.

Top module: `udma_burst`

## Requirements
- R1: After reset: dmack_n is 1, strobe_pin is 1, stop_pin is 1, dd_oe is 0 and udma_active is 0.
- R2: dmack_n is asserted (0), and udma_active goes to 1, only after a start request, in a cycle where dev_dmarq is 1 and pio_busy is 0. While pio_busy is 1 the pins keep PIO meaning. dmack_n is never 0 while udma_active is 0.
- R3: In a write burst (dir_write=1), strobe_pin starts at 1. Each change of strobe_pin, falling or rising, presents the next transmit word on dd_out, in pop order. The word is placed on dd_out one cycle before the strobe edge.
- R4: In a write burst, dev_pin high means the device is paused (active-low ready). Starting from the cycle in which dev_pin rises, at most four more clock cycles may show a change of strobe_pin. No further edge follows until dev_pin returns low.
- R5: In a read burst, every rising or falling edge of dev_pin, seen after the two-flop synchronizer, captures dd_in. The captured word appears on rx_data with a one-cycle rx_push, in arrival order.
- R6: In a read burst, strobe_pin (host ready, active low) equals rx_afull as sampled on the previous clock edge. A high level pauses the device.
- R7: When xfer_count words have moved, stop_pin goes high for exactly one cycle while dmack_n is still 0.
- R8: A CRC-16 with polynomial 0x1021 and seed 0x4ABA is accumulated MSB first over every transferred word. In the cycle after the stop cycle, dmack_n is 1, dd_oe is 1 and dd_out holds the CRC.
- R9: After the CRC cycle, udma_active returns to 0 and burst_done pulses for one cycle. strobe_pin, stop_pin and dmack_n return to 1 and dd_oe to 0.
- R10: In a write burst, if tx_valid is low when the next word is due, the burst stops early (stop, then CRC), and only the words actually popped are counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle burst request |
| dir_write | input | 1 | 1 = write to disk, 0 = read from disk |
| xfer_count | input | CNT_W | Words in the burst |
| pio_busy | input | 1 | A PIO cycle is in progress |
| dev_dmarq | input | 1 | Device DMA request |
| dmack_n | output | 1 | DMA acknowledge, active low |
| strobe_pin | output | 1 | Host write strobe (write) or host ready, active low (read) |
| stop_pin | output | 1 | Burst stop, active high in Ultra DMA |
| dev_pin | input | 1 | Device read strobe (read) or device ready, active low (write) |
| dd_out | output | DW | Data bus output value |
| dd_oe | output | 1 | Data bus output enable |
| dd_in | input | DW | Data bus input value |
| tx_data | input | DW | Transmit word at the head of the source |
| tx_valid | input | 1 | Transmit source not empty |
| tx_pop | output | 1 | Consume the head transmit word this cycle |
| rx_data | output | DW | Received word |
| rx_push | output | 1 | rx_data valid for one cycle |
| rx_afull | input | 1 | Receive sink nearly full |
| udma_active | output | 1 | Pins carry Ultra DMA meaning |
| burst_done | output | 1 | One-cycle pulse at the end of a burst |

## Verification
The assertions assume three things about the inputs. dev_pin changes slowly compared with the clock, and dd_in stays stable from each device strobe edge until the synchronized edge has been taken. tx_data holds while tx_valid is high and no pop happens. rx_afull needs no relation to the strobe at all. The bench device model meets these rules. It toggles its strobe only after it sees host ready low, and it holds each word for six cycles. The transmit source is a queue that changes only after a pop. Every input is driven one time unit after a rising edge, so the synchronizer and the ready path see clean, single-edge changes.

// File: rtl/udma_pkg.sv
package udma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_WR,
        ST_RD,
        ST_STOP,
        ST_CRC
    } burst_state_e;

    localparam logic [15:0] CRC_SEED = 16'h4ABA;
    localparam logic [15:0] CRC_POLY = 16'h1021;
endpackage

// File: rtl/udma_sync_edge.sv
module udma_sync_edge #(
    parameter int   STAGES   = 2,
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic toggled
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {CHAIN_W{IDLE_LVL}};
        else        chain_q <= {chain_q[CHAIN_W-2:0], pin};
    end

    assign level   = chain_q[STAGES-1];
    assign toggled = chain_q[STAGES-1] ^ chain_q[STAGES];
endmodule

// File: rtl/udma_crc16.sv
module udma_crc16 #(
    parameter int          DW   = 16,
    parameter logic [15:0] POLY = 16'h1021
) (
    input  logic [15:0]   crc_in,
    input  logic [DW-1:0] data,
    output logic [15:0]   crc_out
);
    always_comb begin
        logic [15:0] acc;
        logic        fb;
        acc = crc_in;
        for (int i = DW - 1; i >= 0; i--) begin
            fb  = acc[15] ^ data[i];
            acc = {acc[14:0], 1'b0} ^ (fb ? POLY : 16'h0000);
        end
        crc_out = acc;
    end
endmodule

// File: rtl/udma_burst.sv
module udma_burst
    import udma_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CNT_W = 16,
    parameter int SYNC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dir_write,
    input  logic [CNT_W-1:0] xfer_count,
    input  logic             pio_busy,
    input  logic             dev_dmarq,
    output logic             dmack_n,
    output logic             strobe_pin,
    output logic             stop_pin,
    input  logic             dev_pin,
    output logic [DW-1:0]    dd_out,
    output logic             dd_oe,
    input  logic [DW-1:0]    dd_in,
    input  logic [DW-1:0]    tx_data,
    input  logic             tx_valid,
    output logic             tx_pop,
    output logic [DW-1:0]    rx_data,
    output logic             rx_push,
    input  logic             rx_afull,
    output logic             udma_active,
    output logic             burst_done
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        burst_state_e     st;
        logic [CNT_W-1:0] cnt;
        logic             phase;
        logic             wr;
        logic             strobe;
        logic             stop;
        logic             ack_n;
        logic             mode;
        logic [DW-1:0]    dout;
        logic             doe;
        logic [15:0]      crc;
        logic             rxv;
        logic [DW-1:0]    rxd;
        logic             done;
    } regs_t;

    regs_t r_q, r_d;
    logic  dev_level, dev_edge, dev_rdy;
    logic  tx_pop_d;
    logic [DW-1:0] crc_data;
    logic [15:0]   crc_next;

    udma_sync_edge #(.STAGES(SYNC), .IDLE_LVL(1'b1)) u_dev_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (dev_pin),
        .level   (dev_level),
        .toggled (dev_edge)
    );

    assign dev_rdy  = ~dev_level;
    assign crc_data = r_q.wr ? tx_data : dd_in;

    udma_crc16 #(.DW(DW), .POLY(CRC_POLY)) u_crc (
        .crc_in  (r_q.crc),
        .data    (crc_data),
        .crc_out (crc_next)
    );

    always_comb begin
        r_d       = r_q;
        r_d.rxv   = 1'b0;
        r_d.done  = 1'b0;
        tx_pop_d  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                r_d.strobe = 1'b1;
                r_d.stop   = 1'b1;
                r_d.ack_n  = 1'b1;
                r_d.mode   = 1'b0;
                r_d.doe    = 1'b0;
                if (start) begin
                    r_d.wr  = dir_write;
                    r_d.cnt = xfer_count;
                    r_d.crc = CRC_SEED;
                    r_d.st  = ST_ARM;
                end
            end
            ST_ARM: begin
                if (dev_dmarq && !pio_busy) begin
                    r_d.ack_n = 1'b0;
                    r_d.mode  = 1'b1;
                    r_d.stop  = 1'b0;
                    r_d.phase = 1'b0;
                    if (r_q.wr) begin
                        r_d.strobe = 1'b1;
                        r_d.doe    = 1'b1;
                        r_d.st     = ST_WR;
                    end else begin
                        r_d.strobe = rx_afull;
                        r_d.st     = ST_RD;
                    end
                end
            end
            ST_WR: begin
                if (r_q.phase) begin
                    r_d.strobe = ~r_q.strobe;
                    r_d.phase  = 1'b0;
                end else if (r_q.cnt == '0 || !tx_valid) begin
                    r_d.stop = 1'b1;
                    r_d.st   = ST_STOP;
                end else if (dev_rdy) begin
                    tx_pop_d  = 1'b1;
                    r_d.dout  = tx_data;
                    r_d.crc   = crc_next;
                    r_d.cnt   = r_q.cnt - CNT_ONE;
                    r_d.phase = 1'b1;
                end
            end
            ST_RD: begin
                r_d.strobe = rx_afull;
                if (r_q.cnt == '0) begin
                    r_d.stop = 1'b1;
                    r_d.st   = ST_STOP;
                end else if (dev_edge) begin
                    r_d.rxv = 1'b1;
                    r_d.rxd = dd_in;
                    r_d.crc = crc_next;
                    r_d.cnt = r_q.cnt - CNT_ONE;
                end
            end
            ST_STOP: begin
                r_d.ack_n = 1'b1;
                r_d.dout  = r_q.crc;
                r_d.doe   = 1'b1;
                r_d.st    = ST_CRC;
            end
            ST_CRC: begin
                r_d.doe    = 1'b0;
                r_d.mode   = 1'b0;
                r_d.strobe = 1'b1;
                r_d.done   = 1'b1;
                r_d.st     = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_IDLE;
            r_q.strobe <= 1'b1;
            r_q.stop   <= 1'b1;
            r_q.ack_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign dmack_n     = r_q.ack_n;
    assign strobe_pin  = r_q.strobe;
    assign stop_pin    = r_q.stop;
    assign dd_out      = r_q.dout;
    assign dd_oe       = r_q.doe;
    assign tx_pop      = tx_pop_d;
    assign rx_data     = r_q.rxd;
    assign rx_push     = r_q.rxv;
    assign udma_active = r_q.mode;
    assign burst_done  = r_q.done;

    // R2: acknowledge only with Ultra DMA pin meaning
    a_r2_ack_in_mode: assert property (@(posedge clk) disable iff (!rst_n)
        !dmack_n |-> udma_active);

    // R2: entry only when no PIO cycle runs and the device requests
    a_r2_entry_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(udma_active) |-> $past(!pio_busy && dev_dmarq));

    // R3: a pop only when the source has data
    a_r3_pop_valid: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> tx_valid);

    // R4: while paused in the load phase, strobe holds
    a_r4_hold_on_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WR && !r_q.phase && !dev_rdy) |=> $stable(strobe_pin));

    // R6: host ready follows the sink level one cycle later
    a_r6_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RD) |=> (strobe_pin == $past(rx_afull)));

    // R7: stop is one cycle, acknowledge still asserted
    a_r7_stop_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (udma_active && !dmack_n && $rose(stop_pin)) |=> dmack_n);

    // R8: CRC cycle drives the bus with acknowledge released
    a_r8_crc_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(r_q.ack_n) == 1'b0 && $rose(dmack_n) && udma_active) |-> dd_oe);
endmodule

// File: tb/tb_udma_burst.sv
module tb_udma_burst;
    localparam int DW    = 16;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             dir_write = 1'b0;
    logic [CNT_W-1:0] xfer_count = '0;
    logic             pio_busy = 1'b0;
    logic             dev_dmarq = 1'b0;
    logic             dmack_n, strobe_pin, stop_pin;
    logic             dev_pin = 1'b1;
    logic [DW-1:0]    dd_out;
    logic             dd_oe;
    logic [DW-1:0]    dd_in = '0;
    logic [DW-1:0]    tx_data = '0;
    logic             tx_valid = 1'b0;
    logic             tx_pop;
    logic [DW-1:0]    rx_data;
    logic             rx_push;
    logic             rx_afull = 1'b0;
    logic             udma_active, burst_done;

    always #2.5 clk = ~clk;

    udma_burst #(.DW(DW), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_write(dir_write),
        .xfer_count(xfer_count), .pio_busy(pio_busy), .dev_dmarq(dev_dmarq),
        .dmack_n(dmack_n), .strobe_pin(strobe_pin), .stop_pin(stop_pin),
        .dev_pin(dev_pin), .dd_out(dd_out), .dd_oe(dd_oe), .dd_in(dd_in),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_pop(tx_pop),
        .rx_data(rx_data), .rx_push(rx_push), .rx_afull(rx_afull),
        .udma_active(udma_active), .burst_done(burst_done)
    );

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] tx_src[$];
    logic [DW-1:0] exp_wq[$];
    logic [DW-1:0] exp_rq[$];
    logic [15:0]   tb_crc = 16'h4ABA;
    logic          tb_wr = 1'b0;
    int            stop_seen = 0, crc_seen = 0, done_seen = 0, pause_age = 0;
    logic          prev_strobe = 1'b1, prev_mode = 1'b0, prev_stop = 1'b1, afull_last = 1'b0;

    function automatic logic [15:0] crc_step(logic [15:0] c, logic [15:0] w);
        logic [15:0] r;
        r = c;
        for (int b = 15; b >= 0; b--) begin
            if (r[15] != w[b]) r = (r << 1) ^ 16'h1021;
            else               r = r << 1;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic refresh_tx();
        tx_valid = (tx_src.size() > 0);
        tx_data  = (tx_src.size() > 0) ? tx_src[0] : '0;
    endtask

    // transmit source: pops on the edge where tx_pop was high
    initial begin
        forever begin
            logic p;
            @(negedge clk);
            p = tx_pop;
            @(posedge clk);
            #1;
            if (p && tx_src.size() > 0) void'(tx_src.pop_front());
            refresh_tx();
        end
    end

    // per-clock reference comparison
    always @(negedge clk) begin
        if (rst_n) begin
            if (!dmack_n && !udma_active) check(0, "R2", "ack outside mode", 1, 0);
            if (udma_active && prev_mode && tb_wr && strobe_pin != prev_strobe) begin
                if (exp_wq.size() == 0) check(0, "R3", "extra strobe edge", dd_out, 0);
                else begin
                    logic [15:0] e;
                    e = exp_wq.pop_front();
                    check(dd_out == e, "R3", "write word", dd_out, e);
                    tb_crc = crc_step(tb_crc, e);
                end
                check(pause_age <= 4, "R4", "edge during pause", pause_age, 4);
            end
            if (rx_push) begin
                if (exp_rq.size() == 0) check(0, "R5", "extra push", rx_data, 0);
                else begin
                    logic [15:0] e;
                    e = exp_rq.pop_front();
                    check(rx_data == e, "R5", "read word", rx_data, e);
                    tb_crc = crc_step(tb_crc, e);
                end
            end
            if (udma_active && !tb_wr && !dmack_n && !stop_pin && !prev_stop)
                check(strobe_pin == afull_last, "R6", "host ready", strobe_pin, afull_last);
            if (udma_active && !dmack_n && stop_pin && !prev_stop) begin
                stop_seen++;
                check(exp_wq.size() == 0 && exp_rq.size() == 0, "R7", "words left at stop",
                      exp_wq.size() + exp_rq.size(), 0);
            end
            if (udma_active && dmack_n && dd_oe) begin
                crc_seen++;
                check(dd_out == tb_crc, "R8", "crc on bus", dd_out, tb_crc);
            end
            if (burst_done) done_seen++;
            if (udma_active && tb_wr && dev_pin) pause_age++;
            else pause_age = 0;
            prev_strobe = strobe_pin;
            prev_mode   = udma_active;
            prev_stop   = stop_pin;
            afull_last  = rx_afull;
        end
    end

    task automatic finish_checks(input int dn_before);
        while (udma_active) tick();
        dev_dmarq = 1'b0;
        dev_pin   = 1'b1;
        tick();
        check(stop_seen == 1, "R7", "stop pulses", stop_seen, 1);
        check(crc_seen == 1, "R8", "crc cycles", crc_seen, 1);
        check(done_seen == dn_before + 1, "R9", "done pulse", done_seen, dn_before + 1);
        check(dmack_n && strobe_pin && stop_pin && !dd_oe && !udma_active, "R9", "idle pins",
              {dmack_n, strobe_pin, stop_pin, dd_oe, udma_active}, 5'b11100);
    endtask

    task automatic run_write(input int supply, input int count, input bit pause, input bit busy);
        int dn;
        dn = done_seen; stop_seen = 0; crc_seen = 0;
        tb_wr = 1'b1; tb_crc = 16'h4ABA;
        for (int i = 0; i < supply; i++) begin
            logic [15:0] w;
            w = 16'hA500 ^ (16'(i) * 16'h1357) ^ 16'(count << 8);
            tx_src.push_back(w);
            if (i < count) exp_wq.push_back(w);
        end
        refresh_tx();
        dir_write = 1'b1; xfer_count = CNT_W'(count); pio_busy = busy; dev_pin = 1'b0;
        start = 1'b1; tick(); start = 1'b0;
        dev_dmarq = 1'b1;
        if (busy) begin
            repeat (6) tick();
            check(dmack_n && !udma_active, "R2", "held off by pio", dmack_n, 1);
            pio_busy = 1'b0;
            repeat (2) tick();
            check(!dmack_n && udma_active, "R2", "ack after pio", dmack_n, 0);
        end
        while (!udma_active) tick();
        if (pause) begin
            repeat (7) tick();
            dev_pin = 1'b1;
            repeat (15) tick();
            check(exp_wq.size() > 0, "R4", "words still pending after pause", exp_wq.size(), 1);
            dev_pin = 1'b0;
        end
        finish_checks(dn);
        check(exp_wq.size() == 0, "R3", "all words sent", exp_wq.size(), 0);
        if (supply < count)
            check(tx_src.size() == 0, "R10", "early stop consumed source", tx_src.size(), 0);
        tx_src.delete(); exp_wq.delete(); refresh_tx();
    endtask

    task automatic run_read(input int count, input bit pause);
        int dn;
        dn = done_seen; stop_seen = 0; crc_seen = 0;
        tb_wr = 1'b0; tb_crc = 16'h4ABA;
        dir_write = 1'b0; xfer_count = CNT_W'(count); dev_pin = 1'b1;
        start = 1'b1; tick(); start = 1'b0;
        dev_dmarq = 1'b1;
        while (dmack_n) tick();
        for (int i = 0; i < count; i++) begin
            logic [15:0] w;
            while (strobe_pin) tick();
            w = 16'h3C00 + 16'(i * 16'h0111);
            exp_rq.push_back(w);
            dd_in = w;
            dev_pin = ~dev_pin;
            if (pause && i == 3) begin
                rx_afull = 1'b1;
                repeat (10) tick();
                check(strobe_pin == 1'b1, "R6", "paused ready", strobe_pin, 1);
                rx_afull = 1'b0;
            end
            repeat (6) tick();
        end
        finish_checks(dn);
        check(exp_rq.size() == 0, "R5", "all words received", exp_rq.size(), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        check(dmack_n && strobe_pin && stop_pin && !dd_oe && !udma_active, "R1", "reset state",
              {dmack_n, strobe_pin, stop_pin, dd_oe, udma_active}, 5'b11100);
        rst_n = 1'b1;
        repeat (2) tick();
        run_write(6, 6, 1'b0, 1'b0);
        run_write(4, 4, 1'b0, 1'b1);
        run_write(12, 10, 1'b1, 1'b0);
        run_write(3, 8, 1'b0, 1'b0);
        run_read(5, 1'b0);
        run_read(9, 1'b1);
        run_read(1, 1'b0);
        repeat (4) tick();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule